// File: doc/BRIEF.md
# Disk Controller Host Command/Result Port

This block is the processor-facing front end of a disk controller. The host talks to it through one 8-bit port and a single address bit. With the address bit low, the host reads a main status byte. With it high, the host reaches the data register. Every operation runs through three phases in a fixed order. First the host writes the command bytes. Then the execution logic does the work. Last, the host reads back the result bytes.

The first command byte carries the operation code in its low five bits. The block looks up how many command bytes and how many result bytes that operation needs. Once the last command byte arrives, it either presents the collected bytes to the execution logic with a one-cycle valid pulse, or answers at once for the two operations it handles itself.

During execution, the execution logic offers or requests bytes one at a time. The host moves each byte either by interrupt-paced register access or by a DMA request/acknowledge handshake, selected by a mode input. The block watches for bytes that are never serviced and folds an overrun flag into the results. It also drops the DMA request on the same clock edge that ends execution.

Top module: `fdc_host_port`

## Requirements
- R1: With `addrSel`=0, a read returns the status byte: bit 7 ready-for-host, bit 6 direction (1 means controller to host), bit 5 execution in interrupt mode, bit 4 busy, bits 3..0 zero. After reset and whenever idle it reads 80h. In the command phase (after the first byte) it reads 90h. In the result phase it reads D0h.
- R2: The operation code is bits 4..0 of the first data-register write. The command byte counts are:
  - 9 for codes 02h, 05h, 06h, 09h, 0Ch, 11h, 19h and 1Dh;
  - 6 for 0Dh;
  - 3 for 03h and 0Fh;
  - 2 for 04h, 07h and 0Ah;
  - 1 for 08h, 10h and every other code.

  For an executed operation, `cmdValid` is high for exactly the one cycle after the final byte's write edge. In that cycle `cmdOpcode` holds the code, and byte i of the command is on `cmdParams[8i+7:8i]`.
- R3: Result byte counts are:
  - 7 for the nine-byte codes, 0Ah and 0Dh;
  - 2 for 08h;
  - 1 for 04h;
  - 0 for 03h, 07h and 0Fh.

  On `execDone`, byte i of `execResult[8i+7:8i]` becomes result byte i. Results are read in order from the data register, and the port goes idle after the last one. With zero results, it goes idle at `execDone`.
- R4: In interrupt mode (`dmaMode`=0), a pending execution byte raises `irq`, and status reads B0h (host to controller) or F0h (controller to host). A data-register read returns the byte from `xferDataIn`, or a data-register write supplies it. Either access clears the pending byte, and `xferAck` pulses in the next cycle with `xferDataOut` holding the written byte.
- R5: In DMA mode, a pending byte raises `drq` with `irq` low and status 10h. A `dmaAck` pulse completes the transfer: it reads out the byte, or takes `wrData` in.
- R6: `execDone` clears `drq` on its own edge, without any `dmaAck`.
- R7: Two conditions set bit 4 of result byte 1: an `xferReq` arriving while the previous byte is still pending, or `execDone` arriving with a byte still pending. The flag is cleared when the next command starts.
- R8: Code 10h goes straight to the result phase with the single byte 90h and no `cmdValid`.
- R9: Any code outside the table goes straight to the result phase with the single byte 80h and no `cmdValid`.
- R10: A data-register write during the result phase has no effect. A data-register read during the command phase returns 00h and does not disturb the byte count.
- R11: `irq` rises when an executed operation enters its result phase, and falls on the first result read. It stays low for the 10h and unknown-code answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrSel | input | 1 | 0 selects status byte, 1 selects data register |
| hostWr | input | 1 | Host write strobe, one cycle per byte |
| hostRd | input | 1 | Host read strobe, one cycle per byte |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data |
| dmaMode | input | 1 | 1 selects DMA pacing, 0 interrupt pacing |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | DMA request |
| dmaAck | input | 1 | DMA acknowledge, one cycle per byte |
| cmdValid | output | 1 | Command handed to execution logic |
| cmdOpcode | output | 5 | Operation code of the handed-over command |
| cmdParams | output | MAX_CMD*8 | Collected command bytes |
| xferReq | input | 1 | Execution logic has or needs one byte |
| xferToHost | input | 1 | Direction of the requested byte |
| xferDataIn | input | 8 | Byte offered to the host |
| xferAck | output | 1 | Byte transfer completed |
| xferDataOut | output | 8 | Byte supplied by the host |
| execDone | input | 1 | Execution finished, results valid |
| execResult | input | MAX_RES*8 | Result bytes from execution |

## Verification
Each operation code, including randomly drawn unknown ones, is issued in both pacing modes. The resulting byte counts and result streams show whether the lookup table, the parameter capture and the phase sequencing agree. Transfers are driven in both directions, so a mixed-up direction bit or buffer shows up as wrong status or wrong data. Three overrun patterns are compared: no overrun, a back-to-back request, and a byte left unserved at the end. Together they separate the two overrun causes and show the request being withdrawn without an acknowledge. Stray data accesses in the command and result phases expose any counter that moves when it should not.

// File: rtl/fdc_host_pkg.sv
`timescale 1ns/1ps
package fdc_host_pkg;
  localparam int CNT_W = 4;
  localparam logic [7:0] VERSION_BYTE = 8'h90;
  localparam logic [7:0] INVALID_BYTE = 8'h80;
  localparam int OVR_BYTE = 1;
  localparam logic [7:0] OVR_MASK = 8'h10;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_t;
  typedef enum logic [1:0] {SRC_EXEC, SRC_VERSION, SRC_INVALID} resSrc_t;

  typedef struct packed {
    logic [CNT_W-1:0] cmdLen;
    logic [CNT_W-1:0] resLen;
    resSrc_t src;
  } cmdInfo_t;

  typedef struct packed {
    logic paramWe;
    logic [CNT_W-1:0] paramIdx;
    logic resLoad;
    resSrc_t resSrc;
    logic xferCapture;
    logic hostCapture;
    logic ovr;
  } dpStrobe_t;

  function automatic cmdInfo_t decodeOpcode(input logic [4:0] op);
    cmdInfo_t r;
    r.src = SRC_EXEC;
    case (op)
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h11, 5'h19, 5'h1D: begin
        r.cmdLen = 4'd9; r.resLen = 4'd7;
      end
      5'h0A: begin r.cmdLen = 4'd2; r.resLen = 4'd7; end
      5'h0D: begin r.cmdLen = 4'd6; r.resLen = 4'd7; end
      5'h03, 5'h0F: begin r.cmdLen = 4'd3; r.resLen = 4'd0; end
      5'h07: begin r.cmdLen = 4'd2; r.resLen = 4'd0; end
      5'h04: begin r.cmdLen = 4'd2; r.resLen = 4'd1; end
      5'h08: begin r.cmdLen = 4'd1; r.resLen = 4'd2; end
      5'h10: begin r.cmdLen = 4'd1; r.resLen = 4'd1; r.src = SRC_VERSION; end
      default: begin r.cmdLen = 4'd1; r.resLen = 4'd1; r.src = SRC_INVALID; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fdc_host_ctrl.sv
`timescale 1ns/1ps
module fdc_host_ctrl
  import fdc_host_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic dataWr,
  input  logic dataRd,
  input  logic [4:0] opcodeIn,
  input  logic dmaMode,
  input  logic dmaAck,
  input  logic xferReq,
  input  logic xferToHost,
  input  logic execDone,
  output phase_t phase,
  output logic [CNT_W-1:0] resIdx,
  output logic pending,
  output logic pendToHost,
  output dpStrobe_t strobe,
  output logic cmdValid,
  output logic [4:0] cmdOpcode,
  output logic irq,
  output logic drq,
  output logic xferAck,
  output logic [7:0] msr
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] cnt, cmdLen, resLen;
  resSrc_t src, finSrc;
  logic overrun, resIrq;
  cmdInfo_t info;
  logic inCmd, lastByte, svc, doneNow, execIrq;

  assign info     = decodeOpcode(opcodeIn);
  assign inCmd    = (phase == PH_IDLE) || (phase == PH_CMD);
  assign lastByte = dataWr && (((phase == PH_IDLE) && (info.cmdLen == ONE)) ||
                               ((phase == PH_CMD) && (cnt + ONE == cmdLen)));
  assign finSrc   = (phase == PH_IDLE) ? info.src : src;
  assign svc      = (phase == PH_EXEC) && pending &&
                    (dmaMode ? dmaAck : (pendToHost ? dataRd : dataWr));
  assign doneNow  = (phase == PH_EXEC) && execDone;
  assign execIrq  = (phase == PH_EXEC) && !dmaMode && pending;

  always_comb begin
    strobe.paramWe     = dataWr && inCmd;
    strobe.paramIdx    = (phase == PH_IDLE) ? '0 : cnt;
    strobe.resLoad     = (lastByte && (finSrc != SRC_EXEC)) || doneNow;
    strobe.resSrc      = doneNow ? SRC_EXEC : finSrc;
    strobe.xferCapture = (phase == PH_EXEC) && xferReq && !execDone;
    strobe.hostCapture = svc && !pendToHost && !execDone;
    strobe.ovr         = overrun || pending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE; cnt <= '0; cmdLen <= '0; resLen <= '0; resIdx <= '0;
      src <= SRC_EXEC; overrun <= 1'b0; resIrq <= 1'b0; pending <= 1'b0;
      pendToHost <= 1'b0; cmdValid <= 1'b0; cmdOpcode <= '0; xferAck <= 1'b0;
    end else begin
      cmdValid <= 1'b0;
      xferAck  <= 1'b0;
      case (phase)
        PH_IDLE, PH_CMD: begin
          if (dataWr) begin
            if (phase == PH_IDLE) begin
              cmdOpcode <= opcodeIn;
              cmdLen    <= info.cmdLen;
              resLen    <= info.resLen;
              src       <= info.src;
              overrun   <= 1'b0;
              cnt       <= ONE;
            end else begin
              cnt <= cnt + ONE;
            end
            if (lastByte) begin
              if (finSrc == SRC_EXEC) begin
                phase    <= PH_EXEC;
                cmdValid <= 1'b1;
              end else begin
                phase  <= PH_RES;
                resIdx <= '0;
              end
            end else begin
              phase <= PH_CMD;
            end
          end
        end
        PH_EXEC: begin
          if (execDone) begin
            overrun <= overrun || pending;
            pending <= 1'b0;
            resIdx  <= '0;
            if (resLen == '0) begin
              phase <= PH_IDLE;
            end else begin
              phase  <= PH_RES;
              resIrq <= 1'b1;
            end
          end else begin
            if (svc) begin
              pending <= 1'b0;
              xferAck <= 1'b1;
            end
            if (xferReq) begin
              if (pending && !svc) overrun <= 1'b1;
              pending    <= 1'b1;
              pendToHost <= xferToHost;
            end
          end
        end
        PH_RES: begin
          if (dataRd) begin
            resIrq <= 1'b0;
            resIdx <= resIdx + ONE;
            if (resIdx + ONE == resLen) phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign irq = execIrq || resIrq;
  assign drq = (phase == PH_EXEC) && dmaMode && pending;
  assign msr = {inCmd || (phase == PH_RES) || execIrq,
                (phase == PH_RES) || (execIrq && pendToHost),
                (phase == PH_EXEC) && !dmaMode,
                phase != PH_IDLE,
                4'b0000};
endmodule

// File: rtl/fdc_host_datapath.sv
`timescale 1ns/1ps
module fdc_host_datapath
  import fdc_host_pkg::*;
#(
  parameter int MAX_CMD = 9,
  parameter int MAX_RES = 7,
  localparam int PARAM_W = MAX_CMD * 8,
  localparam int RES_W = MAX_RES * 8
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobe_t strobe,
  input  logic [7:0] wrData,
  input  logic [7:0] xferDataIn,
  input  logic [RES_W-1:0] execResult,
  input  phase_t phase,
  input  logic [CNT_W-1:0] resIdx,
  input  logic pending,
  input  logic pendToHost,
  input  logic addrSel,
  input  logic dmaAck,
  input  logic [7:0] msr,
  output logic [7:0] rdData,
  output logic [PARAM_W-1:0] cmdParams,
  output logic [7:0] xferDataOut
);
  logic [RES_W-1:0] resVec;
  logic [7:0] toHostBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdParams   <= '0;
      toHostBuf   <= '0;
      xferDataOut <= '0;
    end else begin
      if (strobe.paramWe) cmdParams[strobe.paramIdx*8 +: 8] <= wrData;
      if (strobe.xferCapture) toHostBuf <= xferDataIn;
      if (strobe.hostCapture) xferDataOut <= (dmaAck || addrSel) ? wrData : xferDataOut;
    end
  end

  for (genvar g = 0; g < MAX_RES; g++) begin : gResByte
    logic [7:0] nxt;
    always_comb begin
      case (strobe.resSrc)
        SRC_EXEC:    nxt = execResult[g*8 +: 8] |
                           (((g == OVR_BYTE) && strobe.ovr) ? OVR_MASK : 8'h00);
        SRC_VERSION: nxt = (g == 0) ? VERSION_BYTE : 8'h00;
        default:     nxt = (g == 0) ? INVALID_BYTE : 8'h00;
      endcase
    end
    always_ff @(posedge clk) begin
      if (!rstN) resVec[g*8 +: 8] <= '0;
      else if (strobe.resLoad) resVec[g*8 +: 8] <= nxt;
    end
  end

  always_comb begin
    if (!addrSel && !dmaAck) rdData = msr;
    else if (phase == PH_RES) rdData = resVec[resIdx*8 +: 8];
    else if ((phase == PH_EXEC) && pending && pendToHost) rdData = toHostBuf;
    else rdData = 8'h00;
  end
endmodule

// File: rtl/fdc_host_port.sv
`timescale 1ns/1ps
module fdc_host_port
  import fdc_host_pkg::*;
#(
  parameter int MAX_CMD = 9,
  parameter int MAX_RES = 7,
  localparam int PARAM_W = MAX_CMD * 8,
  localparam int RES_W = MAX_RES * 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic addrSel,
  input  logic hostWr,
  input  logic hostRd,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic dmaMode,
  output logic irq,
  output logic drq,
  input  logic dmaAck,
  output logic cmdValid,
  output logic [4:0] cmdOpcode,
  output logic [PARAM_W-1:0] cmdParams,
  input  logic xferReq,
  input  logic xferToHost,
  input  logic [7:0] xferDataIn,
  output logic xferAck,
  output logic [7:0] xferDataOut,
  input  logic execDone,
  input  logic [RES_W-1:0] execResult
);
  phase_t phase;
  logic [CNT_W-1:0] resIdx;
  logic pending, pendToHost;
  dpStrobe_t strobe;
  logic [7:0] msr;

  fdc_host_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .dataWr(hostWr && addrSel), .dataRd(hostRd && addrSel),
    .opcodeIn(wrData[4:0]), .dmaMode(dmaMode), .dmaAck(dmaAck),
    .xferReq(xferReq), .xferToHost(xferToHost), .execDone(execDone),
    .phase(phase), .resIdx(resIdx), .pending(pending), .pendToHost(pendToHost),
    .strobe(strobe), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .irq(irq), .drq(drq), .xferAck(xferAck), .msr(msr)
  );

  fdc_host_datapath #(.MAX_CMD(MAX_CMD), .MAX_RES(MAX_RES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .xferDataIn(xferDataIn), .execResult(execResult), .phase(phase),
    .resIdx(resIdx), .pending(pending), .pendToHost(pendToHost),
    .addrSel(addrSel), .dmaAck(dmaAck), .msr(msr),
    .rdData(rdData), .cmdParams(cmdParams), .xferDataOut(xferDataOut)
  );
endmodule

// File: rtl/fdc_host_port_checker.sv
`timescale 1ns/1ps
module fdc_host_port_checker
  import fdc_host_pkg::*;
(
  input logic clk,
  input logic rstN,
  input phase_t phase,
  input logic execDone,
  input logic drq,
  input logic irq,
  input logic cmdValid,
  input logic xferAck,
  input logic hostWr,
  input logic hostRd,
  input logic addrSel,
  input logic dmaMode,
  input logic [7:0] msr,
  input logic [CNT_W-1:0] resIdx
);
  assert_idle_status_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> (msr == 8'h80));

  assert_handoff_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_handoff_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ((phase == PH_EXEC) && msr[4] && !msr[7]));

  assert_ack_follows_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    xferAck |-> $past(irq || drq));

  assert_dma_quiet_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaMode && (phase == PH_EXEC)) |-> !irq);

  assert_drq_cleanup_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_EXEC) && execDone) |=> !drq);

  assert_result_write_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_RES) && hostWr && addrSel && !hostRd) |=> $stable(resIdx));
endmodule

bind fdc_host_port fdc_host_port_checker u_chk (
  .clk(clk), .rstN(rstN), .phase(phase), .execDone(execDone), .drq(drq),
  .irq(irq), .cmdValid(cmdValid), .xferAck(xferAck), .hostWr(hostWr),
  .hostRd(hostRd), .addrSel(addrSel), .dmaMode(dmaMode), .msr(msr),
  .resIdx(resIdx)
);

// File: tb/fdc_host_port_test.sv
`timescale 1ns/1ps
module fdc_host_port_test;
  localparam int NC = 9;
  localparam int NR = 7;

  logic clk = 1'b0;
  logic rstN, addrSel, hostWr, hostRd, dmaMode, dmaAck;
  logic xferReq, xferToHost, execDone;
  logic [7:0] wrData, rdData, xferDataIn, xferDataOut;
  logic irq, drq, cmdValid, xferAck;
  logic [4:0] cmdOpcode;
  logic [NC*8-1:0] cmdParams;
  logic [NR*8-1:0] execResult;
  int tests = 0;
  int fails = 0;

  fdc_host_port #(.MAX_CMD(NC), .MAX_RES(NR)) uut (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .hostWr(hostWr), .hostRd(hostRd),
    .wrData(wrData), .rdData(rdData), .dmaMode(dmaMode), .irq(irq), .drq(drq),
    .dmaAck(dmaAck), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .cmdParams(cmdParams), .xferReq(xferReq), .xferToHost(xferToHost),
    .xferDataIn(xferDataIn), .xferAck(xferAck), .xferDataOut(xferDataOut),
    .execDone(execDone), .execResult(execResult)
  );

  always #2.5 clk = ~clk;

  function automatic int expCmdLen(input logic [4:0] op);
    case (op)
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h11, 5'h19, 5'h1D: return 9;
      5'h0D: return 6;
      5'h03, 5'h0F: return 3;
      5'h04, 5'h07, 5'h0A: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int expResLen(input logic [4:0] op);
    case (op)
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h11, 5'h19, 5'h1D, 5'h0A, 5'h0D: return 7;
      5'h08: return 2;
      5'h04: return 1;
      5'h03, 5'h07, 5'h0F: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic bit isLocal(input logic [4:0] op);
    return (expCmdLen(op) == 1) && (op != 5'h08);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic a, input logic [7:0] d);
    @(negedge clk); addrSel = a; wrData = d; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic rdByte(input logic a, output logic [7:0] v);
    @(negedge clk); addrSel = a; hostRd = 1'b1;
    #1 v = rdData;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic pulseReq(input logic toHost, input logic [7:0] d);
    @(negedge clk); xferReq = 1'b1; xferToHost = toHost; xferDataIn = d;
    @(negedge clk); xferReq = 1'b0;
  endtask

  task automatic dmaXfer(input logic [7:0] h, output logic [7:0] v);
    @(negedge clk); wrData = h; dmaAck = 1'b1;
    #1 v = rdData;
    @(negedge clk); dmaAck = 1'b0;
  endtask

  task automatic runCmd(input logic [4:0] op, input bit dma, input int nX, input int ovMode);
    logic [7:0] params [NC];
    logic [7:0] res [NR];
    logic [7:0] v, d, h;
    logic dir;
    int cl, rl;
    bit ovFlag;
    cl = expCmdLen(op);
    rl = expResLen(op);
    ovFlag = 0;
    dmaMode = dma;
    for (int i = 0; i < cl; i++) begin
      params[i] = (i == 0) ? {3'($urandom), op} : 8'($urandom);
      wrByte(1'b1, params[i]);
      if (i < cl - 1) check("R2 no early handoff", {7'd0, cmdValid}, 8'h00);
      if (i == 0 && cl > 1) begin
        rdByte(1'b0, v); check("R1 status in command phase", v, 8'h90);
        rdByte(1'b1, v); check("R10 data read in command phase", v, 8'h00);
      end
    end
    if (isLocal(op)) begin
      check("R2 no handoff for local answer", {7'd0, cmdValid}, 8'h00);
      check("R11 no irq for local answer", {7'd0, irq}, 8'h00);
      rdByte(1'b0, v); check("R1 status in result phase", v, 8'hD0);
      rdByte(1'b1, v);
      if (op == 5'h10) check("R8 version byte", v, 8'h90);
      else check("R9 invalid byte", v, 8'h80);
      rdByte(1'b0, v); check("R1 idle after local answer", v, 8'h80);
      return;
    end
    check("R2 handoff pulse", {7'd0, cmdValid}, 8'h01);
    check("R2 handoff opcode", {3'd0, cmdOpcode}, {3'd0, op});
    for (int i = 0; i < cl; i++) check("R2 parameter byte", cmdParams[i*8 +: 8], params[i]);
    rdByte(1'b0, v); check("R2 handoff single cycle", {7'd0, cmdValid}, 8'h00);
    check(dma ? "R5 status dma exec" : "R4 status int exec", v, dma ? 8'h10 : 8'h30);
    for (int k = 0; k < nX; k++) begin
      dir = 1'($urandom); d = 8'($urandom);
      pulseReq(dir, d);
      if (ovMode == 1 && k == 0) begin
        dir = 1'($urandom); d = 8'($urandom);
        pulseReq(dir, d);
        ovFlag = 1;
      end
      check(dma ? "R5 drq on pending" : "R4 irq on pending", {6'd0, irq, drq},
            dma ? 8'h01 : 8'h02);
      if (ovMode == 2 && k == nX - 1) begin
        ovFlag = 1;
        break;
      end
      if (!dma) begin
        rdByte(1'b0, v);
        check("R4 status pending", v, dir ? 8'hF0 : 8'hB0);
      end
      h = 8'($urandom);
      if (dma) dmaXfer(h, v);
      else if (dir) rdByte(1'b1, v);
      else wrByte(1'b1, h);
      if (dir) check(dma ? "R5 dma read data" : "R4 host read data", v, d);
      check(dma ? "R5 ack" : "R4 ack", {7'd0, xferAck}, 8'h01);
      if (!dir) check(dma ? "R5 dma write data" : "R4 host write data", xferDataOut, h);
      check(dma ? "R5 drq cleared" : "R4 irq cleared", {6'd0, irq, drq}, 8'h00);
    end
    for (int j = 0; j < NR; j++) res[j] = 8'($urandom);
    @(negedge clk);
    execDone = 1'b1;
    for (int j = 0; j < NR; j++) execResult[j*8 +: 8] = res[j];
    @(negedge clk); execDone = 1'b0;
    check("R6 drq dropped at end", {7'd0, drq}, 8'h00);
    if (rl == 0) begin
      rdByte(1'b0, v); check("R3 idle with no results", v, 8'h80);
      return;
    end
    check("R11 irq at result entry", {7'd0, irq}, 8'h01);
    rdByte(1'b0, v); check("R1 status in result phase", v, 8'hD0);
    wrByte(1'b1, 8'($urandom));
    for (int j = 0; j < rl; j++) begin
      rdByte(1'b1, v);
      if (j == 1) check("R7 overrun flag in byte 1", v, res[1] | (ovFlag ? 8'h10 : 8'h00));
      else check(j == 0 ? "R10 R3 first result after ignored write" : "R3 result byte", v, res[j]);
      if (j == 0) check("R11 irq cleared by first read", {7'd0, irq}, 8'h00);
    end
    rdByte(1'b0, v); check("R3 idle after results", v, 8'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [4:0] op;
    int nX;
    void'($urandom(32'd7391));
    rstN = 1'b0; addrSel = 1'b0; hostWr = 1'b0; hostRd = 1'b0; wrData = '0;
    dmaMode = 1'b0; dmaAck = 1'b0; xferReq = 1'b0; xferToHost = 1'b0;
    xferDataIn = '0; execDone = 1'b0; execResult = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset irq drq valid", {5'd0, irq, drq, cmdValid}, 8'h00);
    rdByte(1'b0, v); check("R1 reset status", v, 8'h80);

    runCmd(5'h10, 1'b0, 0, 0);
    runCmd(5'h00, 1'b0, 0, 0);
    runCmd(5'h06, 1'b0, 2, 0);
    runCmd(5'h06, 1'b0, 2, 2);
    runCmd(5'h05, 1'b1, 2, 2);
    runCmd(5'h0C, 1'b1, 3, 1);
    runCmd(5'h0F, 1'b0, 0, 0);
    runCmd(5'h08, 1'b1, 0, 0);
    runCmd(5'h04, 1'b0, 1, 0);

    for (int n = 0; n < 60; n++) begin
      op = 5'($urandom);
      nX = isLocal(op) ? 0 : int'($urandom % 4);
      runCmd(op, 1'($urandom), nX, (nX == 0) ? 0 : int'($urandom % 3));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule